// File: doc/BRIEF.md
# Scanline-Counted Raster Interrupt Generator

This block produces a periodic processor interrupt from the display timing. It does this by counting the ends of horizontal sync pulses. A 6-bit line counter advances once for each falling edge of the horizontal sync input. The count runs from 0 to 51. The step after 51 wraps the counter to 0 and sets a pending interrupt request. That request stays high until the processor acknowledges it. Setting the request does not disturb the counter, so with one sync per scanline the interrupts keep a steady 52-line spacing.

Software can move that spacing in several ways:
- An acknowledge clears the 32-weight bit of the counter. An acknowledge that arrives while the count is 32 or more therefore pulls the next interrupt 32 lines closer.
- A clear strobe restarts the count from zero. This pushes the next interrupt further out.
- Extra horizontal sync pulses within one scanline make the counter advance faster.

Vertical sync also realigns the counter. At the second horizontal sync end after vertical sync rises, the counter is forced to zero. If the count was 32 or more at that moment, an interrupt is raised as well. This keeps the interrupt phase locked to the frame.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset, `irq_req_o` is low and the line counter is zero.
- R2: Each falling edge of `hsync_i` advances the counter by one. The advance that would reach 52 sets the counter to 0 and sets `irq_req_o`. The output changes after the first clock edge that sees `hsync_i` low following a high sample.
- R3: A high level on `hsync_i` held across many clocks counts as one line, no matter how long it lasts.
- R4: Once set, `irq_req_o` stays high until an acknowledge or a clear. Setting it leaves the counter untouched, so without acknowledges the next request comes 52 lines later.
- R5: A one-cycle `irq_ack_i` drops `irq_req_o` on the next clock. When the counter is below 32, the acknowledge leaves the counter unchanged.
- R6: An acknowledge while the counter is 32 or more removes 32 from the count by clearing bit 5. Example: an acknowledge at count 40 makes the next request come 44 lines later.
- R7: `cnt_clr_i` sets the counter to 0 and drops `irq_req_o`, taking precedence over every other input in that cycle. The next request then comes 52 lines later.
- R8: On the second falling edge of `hsync_i` after a rising edge of `vsync_i`, the counter is set to 0 instead of advancing. `irq_req_o` is set at that edge only if the count was 32 or more.
- R9: When an acknowledge and a horizontal sync end fall in the same cycle, bit 5 is cleared first and the advance is applied to the result. An acknowledge at count 51 on a line end therefore gives a count of 20 and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which every input is sampled |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync level; its falling edge ends a line |
| vsync_i | input | 1 | Vertical sync level; its rising edge arms the realignment |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe from the processor |
| cnt_clr_i | input | 1 | Software strobe that clears the counter and the request |
| irq_req_o | output | 1 | Pending interrupt request, held until acknowledged or cleared |

## Verification
Two functions can land in the same clock: the acknowledge, which rewrites bit 5 of the counter, and a horizontal sync end, which advances the counter. Because both touch the counter, the order in which they apply decides whether a request is raised.

The bench forces this collision directly. It counts up to 51, then drops `hsync_i` in the very cycle that `irq_ack_i` pulses. It then expects no request and a gap of exactly 32 further lines to the next one. Random traffic produces the same overlap, as well as overlaps with clear and realignment, many more times. Each of those cycles is judged against a cycle-accurate reference model kept in the bench.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

  // Per-cycle line events handed from the sync front end to the counter.
  typedef struct packed {
    logic line_end;   // falling edge of horizontal sync seen this cycle
    logic realign;    // this line end is the frame realignment point
  } rirq_evt_t;

endpackage

// File: rtl/rirq_rst_sync.sv
module rirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rirq_edge.sv
module rirq_edge #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic pulse_o
);

  logic sig_q;
  logic sig_d;

  always_comb begin
    sig_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
    end else begin
      sig_q <= sig_d;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse_o = sig_q & ~sig_i;
    end else begin : g_rise
      assign pulse_o = ~sig_q & sig_i;
    end
  endgenerate

  // A detected edge needs a level change; two in a row are impossible.
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R3

endmodule

// File: rtl/rirq_vs_align.sv
module rirq_vs_align #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_rise_i,
  input  logic line_end_i,
  output logic realign_o
);

  localparam int AW = $clog2(DLY + 1);
  localparam logic [AW-1:0] ARM_LOAD = AW'(DLY);
  localparam logic [AW-1:0] ARM_ONE  = AW'(1);

  logic [AW-1:0] arm_q;
  logic [AW-1:0] arm_d;
  logic          arm_en;

  always_comb begin
    arm_en = 1'b0;
    arm_d  = arm_q;
    if (vs_rise_i) begin
      arm_en = 1'b1;
      arm_d  = ARM_LOAD;
    end else if (line_end_i && (arm_q != '0)) begin
      arm_en = 1'b1;
      arm_d  = arm_q - ARM_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else if (arm_en) begin
      arm_q <= arm_d;
    end
  end

  assign realign_o = line_end_i && (arm_q == ARM_ONE);

  AST_ARM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q <= ARM_LOAD); // R8

  AST_REALIGN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_o && !vs_rise_i) |=> (arm_q == '0)); // R8

endmodule

// File: rtl/rirq_line_ctr.sv
module rirq_line_ctr
  import rirq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int PERIOD = 52,
  parameter int HI_BIT = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rirq_evt_t evt_i,
  input  logic      ack_i,
  input  logic      clr_i,
  output logic      pend_o
);

  localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HI_MASK = ~(CNT_W'(1) << HI_BIT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] base;
  logic             pend_q;
  logic             pend_d;
  logic             upd_en;

  // Acknowledge trims the high-phase bit before any line advance.
  always_comb begin
    base   = ack_i ? (cnt_q & HI_MASK) : cnt_q;
    upd_en = clr_i | ack_i | evt_i.line_end;
    cnt_d  = base;
    pend_d = pend_q & ~ack_i;
    if (clr_i) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (evt_i.line_end) begin
      if (evt_i.realign) begin
        cnt_d = '0;
        if (base[HI_BIT]) begin
          pend_d = 1'b1;
        end
      end else if (base == LAST) begin
        cnt_d  = '0;
        pend_d = 1'b1;
      end else begin
        cnt_d = base + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_PEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(evt_i.line_end)); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i && !clr_i) |=> pend_q); // R4

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i.line_end) |=> !pend_q); // R5

  AST_ACK_HI_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i.line_end) |=> !cnt_q[HI_BIT]); // R6

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && !pend_q); // R7

  AST_REALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.line_end && evt_i.realign && !clr_i) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import rirq_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int PERIOD   = 52,
  parameter int HI_BIT   = 5,
  parameter int VS_DLY   = 2,
  parameter int RST_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic irq_ack_i,
  input  logic cnt_clr_i,
  output logic irq_req_o
);

  logic      rst_int_n;
  logic      hs_end;
  logic      vs_rise;
  logic      realign;
  rirq_evt_t evt;

  rirq_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rirq_edge #(.FALLING(1'b1)) u_hs_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sig_i   (hsync_i),
    .pulse_o (hs_end)
  );

  rirq_edge #(.FALLING(1'b0)) u_vs_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sig_i   (vsync_i),
    .pulse_o (vs_rise)
  );

  rirq_vs_align #(.DLY(VS_DLY)) u_align (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .vs_rise_i  (vs_rise),
    .line_end_i (hs_end),
    .realign_o  (realign)
  );

  always_comb begin
    evt.line_end = hs_end;
    evt.realign  = realign;
  end

  rirq_line_ctr #(
    .CNT_W  (CNT_W),
    .PERIOD (PERIOD),
    .HI_BIT (HI_BIT)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt_i  (evt),
    .ack_i  (irq_ack_i),
    .clr_i  (cnt_clr_i),
    .pend_o (irq_req_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> !irq_req_o); // R1

endmodule

// File: tb/raster_irq_gen_bench.sv
`timescale 1ns/1ps
module raster_irq_gen_bench;

  logic clk = 1'b0;
  logic rst_n, hsync, vsync, ack, clr;
  logic irq;

  always #2.5 clk = ~clk;

  raster_irq_gen u_raster_irq_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_i   (hsync),
    .vsync_i   (vsync),
    .irq_ack_i (ack),
    .cnt_clr_i (clr),
    .irq_req_o (irq)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  bit    model_on = 1'b0;
  string cur_tag = "R1";

  int m_cnt, m_arm;
  bit m_pend, m_hsp, m_vsp;

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s irq_req got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s lines got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int trim_hi(input int c, input bit a);
    return a ? (c & ~32) : c;
  endfunction

  // Reference model of one clock edge, written from the requirements.
  task automatic model_step();
    bit fall, vsr, realign;
    int base;
    fall    = m_hsp && !hsync;
    vsr     = vsync && !m_vsp;
    realign = fall && (m_arm == 1);
    base    = trim_hi(m_cnt, ack);
    if (clr) begin
      m_cnt  = 0;
      m_pend = 1'b0;
    end else begin
      m_pend = m_pend && !ack;
      m_cnt  = base;
      if (fall) begin
        if (realign) begin
          if (base >= 32) m_pend = 1'b1;
          m_cnt = 0;
        end else if (base == 51) begin
          m_cnt  = 0;
          m_pend = 1'b1;
        end else begin
          m_cnt = base + 1;
        end
      end
    end
    if (vsr) m_arm = 2;
    else if (fall && m_arm != 0) m_arm = m_arm - 1;
    m_hsp = hsync;
    m_vsp = vsync;
  endtask

  task automatic cyc();
    @(posedge clk);
    if (model_on) model_step();
    @(negedge clk);
    if (model_on) check(irq, m_pend, cur_tag);
  endtask

  task automatic line();
    hsync = 1'b1; cyc(); cyc();
    hsync = 1'b0; cyc(); cyc();
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) line();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic lines_to_irq(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      line();
      n++;
      if (irq) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; ack = 1'b0; clr = 1'b0;
    m_cnt = 0; m_arm = 0; m_pend = 1'b0; m_hsp = 1'b0; m_vsp = 1'b0;
    repeat (4) @(negedge clk);
    check(irq, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq, 1'b0, "R1 after reset");
    model_on = 1'b1;

    cur_tag = "R2";
    lines_to_irq(n);
    check_int(n, 52, "R2 first period");

    cur_tag = "R4";
    lines(10);
    check(irq, 1'b1, "R4 held pending");

    cur_tag = "R5";
    pulse_ack();
    check(irq, 1'b0, "R5 ack drops request");
    lines_to_irq(n);
    check_int(n, 42, "R5 low ack keeps count");

    cur_tag = "R6";
    lines(40);
    pulse_ack();
    lines_to_irq(n);
    check_int(n, 44, "R6 late ack at 40");

    cur_tag = "R7";
    pulse_ack();
    lines(10);
    clr = 1'b1; ack = 1'b1; hsync = 1'b0; cyc(); clr = 1'b0; ack = 1'b0;
    check(irq, 1'b0, "R7 clear drops request");
    lines_to_irq(n);
    check_int(n, 52, "R7 clear restarts count");

    cur_tag = "R3";
    pulse_ack();
    hsync = 1'b1;
    repeat (20) cyc();
    hsync = 1'b0; cyc(); cyc();
    lines_to_irq(n);
    check_int(n, 51, "R3 long sync counts once");

    cur_tag = "R8";
    pulse_ack();
    lines(40);
    vsync = 1'b1; cyc();
    line();
    check(irq, 1'b0, "R8 first line after vsync");
    line();
    check(irq, 1'b1, "R8 realign from high count");
    vsync = 1'b0;
    pulse_ack();
    lines_to_irq(n);
    check_int(n, 52, "R8 realign zeroes count");
    pulse_ack();
    lines(10);
    vsync = 1'b1; cyc();
    lines(2);
    vsync = 1'b0;
    check(irq, 1'b0, "R8 realign from low count");
    lines_to_irq(n);
    check_int(n, 52, "R8 low realign zeroes count");

    cur_tag = "R9";
    pulse_ack();
    lines(51);
    check(irq, 1'b0, "R9 count at 51");
    hsync = 1'b1; cyc(); cyc();
    hsync = 1'b0; ack = 1'b1; cyc(); ack = 1'b0; cyc();
    check(irq, 1'b0, "R9 ack with line end");
    lines_to_irq(n);
    check_int(n, 32, "R9 count resumed at 20");

    cur_tag = "R2 random";
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 2) == 0) hsync = ~hsync;
      if ($urandom_range(0, 199) == 0) vsync = ~vsync;
      ack = ($urandom_range(0, 39) == 0);
      clr = ($urandom_range(0, 299) == 0);
      cyc();
    end
    ack = 1'b0; clr = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule